// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting timer channel for a peripheral subsystem. Software sets it up by writing a control byte to the control port and then a count through the data port. It can run in three ways. It can raise one interrupt when the count expires. It can produce a periodic tick. It can give a one-shot strobe that is armed again by each new count. A latch command copies the live count into a holding register, so that the count can be read as two bytes while the counter keeps running.

Three small state machines make up the channel. The write-side machine `pit_prog` decodes control bytes and assembles the count bytes. It has two states: `PTR_LO` waits for the low byte, and `PTR_HI` waits for the high byte. Transitions:
- `PTR_LO` goes to `PTR_HI` on a low-byte write in two-byte access.
- `PTR_HI` goes back to `PTR_LO` on the high-byte write, which also loads the count.
- Any accepted control byte forces `PTR_LO`.

The counting machine `pit_counter` has three states:
- `CS_IDLE`: configured but no count loaded yet.
- `CS_RUN`: counting down.
- `CS_DONE`: terminal count has passed, and the counter keeps decrementing silently.

Its transitions:
- A count load goes to `CS_RUN`.
- In terminal-count or strobe mode, `CS_RUN` goes to `CS_DONE` when the count steps from 1 to 0.
- An accepted control byte goes to `CS_IDLE`.

The read-side machine `pit_readout` has four states: `RD_LIVE_LO`, `RD_LIVE_HI`, `RD_HELD_LO` and `RD_HELD_HI`. Each data read toggles between the low and high half. A latch command moves from either live state to `RD_HELD_LO`. A read in `RD_HELD_HI` releases the latch and returns to `RD_LIVE_LO`. An accepted control byte returns to `RD_LIVE_LO`.

Top module: `pit_channel`

## Requirements
- R1: After reset, `tmr_out` and `irq` are low, the live count is 0 so a data-port read returns 0, and data writes are ignored until a control byte is accepted.
- R2: A control byte is written with `ctl_sel`=1. Its fields are: bits [7:6] channel, bits [5:4] access (00 latch, 01 low only, 10 high only, 11 low then high), bits [3:1] mode (000 terminal-count interrupt, 010 rate generator, 100 software strobe), and bit 0 BCD. A byte is ignored if its channel differs from `CHAN_ID`. A non-latch byte is also ignored if it has BCD=1 or any other mode code. An accepted non-latch byte stops counting and sets `tmr_out` low for mode 000 and high for modes 010 and 100, at the edge that samples it.
- R3: Data writes use `ctl_sel`=0. Access 11 takes the low byte and then the high byte, and the count loads only at the high-byte edge. Access 01 loads at once with a high byte of 0. Access 10 loads at once with a low byte of 0. An accepted control byte resets the byte pointer to the low byte.
- R4: In mode 000, `tmr_out` is low from the load. It goes high at the N-th edge after the load edge and stays high. `irq` pulses once, in the cycle after that edge.
- R5: In mode 010 with N ≥ 2, `tmr_out` is low for exactly one cycle every N cycles. The first low cycle follows the (N-1)-th edge after the load. `irq` pulses in each low cycle and the counter reloads N by itself.
- R6: In mode 100, `tmr_out` is low and `irq` pulses for one cycle, after the N-th edge following the load. Nothing further happens until a new count is written, and each new count arms exactly one more strobe.
- R7: A loaded count of 0 behaves as 65536.
- R8: A latch command (access 00, matching channel) captures the count as it was before that edge, and counting continues. The next two data reads return its low byte and then its high byte, and after that the latch is released. A latch command while a latch is held is ignored.
- R9: With no latch held, data reads alternately return the low and high byte of the live count in the cycle of the read. A read with `ctl_sel`=1 returns 0.
- R10: `irq` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| ctl_sel | input | 1 | 1 selects the control port, 0 the data port |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from the read state |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Control and count writes act at the clock edge that samples them. `tmr_out` therefore shows the mode's initial level in the cycle right after that edge. A terminal event for a count N loaded at edge P appears in the cycle after edge P+N. For the periodic mode the first event follows edge P+N-1, and later events come every N edges after that. Read data is combinational and is sampled within the cycle in which the read strobe is raised.

The bench stamps each write with its edge index and puts the expected interrupt cycles in a queue. A monitor compares every interrupt against the head of that queue, and it flags both extra pulses and missed pulses. Latched and live read values are computed from the same edge stamps.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        MD_TERM   = 2'd0,
        MD_RATE   = 2'd1,
        MD_STROBE = 2'd2
    } mode_e;

    typedef struct packed {
        logic [1:0] chan;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_t;
endpackage

// File: rtl/pit_prog.sv
module pit_prog
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              addr_ctl,
    input  logic [BYTE_W-1:0] wdata,
    output logic              cfg_stb,
    output mode_e             cfg_mode,
    output mode_e             mode_q,
    output logic              latch_stb,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val
);
    typedef enum logic {PTR_LO, PTR_HI} ptr_e;

    ctrl_t             cw;
    ptr_e              ptr_q, ptr_d;
    acc_e              acc_q;
    logic [BYTE_W-1:0] lo_q;
    logic              ctl_wr, dat_wr, chan_ok, mode_ok;

    assign cw     = ctrl_t'(wdata);
    assign ctl_wr = wr_stb && addr_ctl;
    assign dat_wr = wr_stb && !addr_ctl;

    // control byte decode
    always_comb begin
        chan_ok  = (cw.chan == CHAN_ID);
        cfg_mode = MD_TERM;
        mode_ok  = 1'b0;
        unique case (cw.mode)
            3'b000:  begin cfg_mode = MD_TERM;   mode_ok = 1'b1; end
            3'b010:  begin cfg_mode = MD_RATE;   mode_ok = 1'b1; end
            3'b100:  begin cfg_mode = MD_STROBE; mode_ok = 1'b1; end
            default: begin cfg_mode = MD_TERM;   mode_ok = 1'b0; end
        endcase
        latch_stb = ctl_wr && chan_ok && (cw.acc == ACC_LATCH);
        cfg_stb   = ctl_wr && chan_ok && (cw.acc != ACC_LATCH) && mode_ok && !cw.bcd;
    end

    // byte pointer next state and count assembly
    always_comb begin
        ptr_d    = ptr_q;
        load_stb = 1'b0;
        load_val = '0;
        if (cfg_stb) begin
            ptr_d = PTR_LO;
        end else if (dat_wr) begin
            unique case (acc_q)
                ACC_LATCH: ;
                ACC_LO: begin
                    load_stb = 1'b1;
                    load_val = {{BYTE_W{1'b0}}, wdata};
                end
                ACC_HI: begin
                    load_stb = 1'b1;
                    load_val = {wdata, {BYTE_W{1'b0}}};
                end
                ACC_LOHI: begin
                    unique case (ptr_q)
                        PTR_LO: ptr_d = PTR_HI;
                        PTR_HI: begin
                            ptr_d    = PTR_LO;
                            load_stb = 1'b1;
                            load_val = {wdata, lo_q};
                        end
                    endcase
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= PTR_LO;
        else        ptr_q <= ptr_d;
    end

    // configuration and low-byte holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= ACC_LATCH;
            mode_q <= MD_TERM;
            lo_q   <= '0;
        end else begin
            if (cfg_stb) begin
                acc_q  <= cw.acc;
                mode_q <= cfg_mode;
            end
            if (dat_wr && acc_q == ACC_LOHI && ptr_q == PTR_LO) lo_q <= wdata;
        end
    end

    // R3
    ptr_lo_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stb |=> (ptr_q == PTR_LO));
endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_stb,
    input  mode_e            cfg_mode,
    input  mode_e            mode_q,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tmr_out,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    typedef enum logic [1:0] {CS_IDLE, CS_RUN, CS_DONE} cst_e;

    cst_e             state_q, state_d;
    logic [CNT_W-1:0] reload_q;

    // next state
    always_comb begin
        state_d = state_q;
        if (cfg_stb)       state_d = CS_IDLE;
        else if (load_stb) state_d = CS_RUN;
        else begin
            unique case (state_q)
                CS_IDLE: ;
                CS_RUN:  if (cnt_q == ONE && mode_q != MD_RATE) state_d = CS_DONE;
                CS_DONE: ;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // count and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
            tmr_out  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (cfg_stb) begin
                tmr_out <= (cfg_mode != MD_TERM);
            end else if (load_stb) begin
                cnt_q    <= load_val;
                reload_q <= load_val;
                tmr_out  <= (mode_q != MD_TERM);
            end else begin
                unique case (state_q)
                    CS_IDLE: ;
                    CS_RUN: begin
                        unique case (mode_q)
                            MD_TERM: begin
                                cnt_q <= cnt_q - ONE;
                                if (cnt_q == ONE) begin
                                    tmr_out <= 1'b1;
                                    irq     <= 1'b1;
                                end
                            end
                            MD_RATE: begin
                                if (cnt_q == ONE) begin
                                    cnt_q   <= reload_q;
                                    tmr_out <= 1'b1;
                                end else begin
                                    cnt_q <= cnt_q - ONE;
                                    if (cnt_q == TWO) begin
                                        tmr_out <= 1'b0;
                                        irq     <= 1'b1;
                                    end
                                end
                            end
                            MD_STROBE: begin
                                cnt_q <= cnt_q - ONE;
                                if (cnt_q == ONE) begin
                                    tmr_out <= 1'b0;
                                    irq     <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                    CS_DONE: begin
                        cnt_q   <= cnt_q - ONE;
                        tmr_out <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5
    rate_low_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_RUN && mode_q == MD_RATE && !tmr_out && !cfg_stb && !load_stb)
        |=> tmr_out);

    // R6
    strobe_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode_q == MD_STROBE) |-> !tmr_out);

    // R4
    term_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_DONE && mode_q == MD_TERM) |-> tmr_out);
endmodule

// File: rtl/pit_readout.sv
module pit_readout
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stb,
    input  logic              latch_stb,
    input  logic              rd_stb,
    input  logic [CNT_W-1:0]  cnt,
    output logic [BYTE_W-1:0] rd_byte
);
    typedef enum logic [1:0] {RD_LIVE_LO, RD_LIVE_HI, RD_HELD_LO, RD_HELD_HI} rst_e;

    rst_e             state_q, state_d;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] src;
    logic             held, live;

    assign held = (state_q == RD_HELD_LO) || (state_q == RD_HELD_HI);
    assign live = !held;

    // next state
    always_comb begin
        state_d = state_q;
        if (cfg_stb)                state_d = RD_LIVE_LO;
        else if (latch_stb && live) state_d = RD_HELD_LO;
        else if (rd_stb) begin
            unique case (state_q)
                RD_LIVE_LO: state_d = RD_LIVE_HI;
                RD_LIVE_HI: state_d = RD_LIVE_LO;
                RD_HELD_LO: state_d = RD_HELD_HI;
                RD_HELD_HI: state_d = RD_LIVE_LO;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_LIVE_LO;
        else        state_q <= state_d;
    end

    // holding register
    always_ff @(posedge clk) begin
        if (!rst_n)                 hold_q <= '0;
        else if (latch_stb && live) hold_q <= cnt;
    end

    // output byte select
    always_comb begin
        src = held ? hold_q : cnt;
        unique case (state_q)
            RD_LIVE_LO, RD_HELD_LO: rd_byte = src[BYTE_W-1:0];
            RD_LIVE_HI, RD_HELD_HI: rd_byte = src[CNT_W-1:BYTE_W];
        endcase
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(hold_q));

    // R8
    release_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_HELD_HI && rd_stb && !cfg_stb && !latch_stb)
        |=> (state_q == RD_LIVE_LO));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              ctl_sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              tmr_out,
    output logic              irq
);
    logic              cfg_stb, latch_stb, load_stb;
    mode_e             cfg_mode, mode_q;
    logic [CNT_W-1:0]  load_val, cnt;
    logic [BYTE_W-1:0] rd_byte;

    pit_prog #(.CHAN_ID(CHAN_ID)) u_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_en),
        .addr_ctl  (ctl_sel),
        .wdata     (wdata),
        .cfg_stb   (cfg_stb),
        .cfg_mode  (cfg_mode),
        .mode_q    (mode_q),
        .latch_stb (latch_stb),
        .load_stb  (load_stb),
        .load_val  (load_val)
    );

    pit_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_stb  (cfg_stb),
        .cfg_mode (cfg_mode),
        .mode_q   (mode_q),
        .load_stb (load_stb),
        .load_val (load_val),
        .cnt_q    (cnt),
        .tmr_out  (tmr_out),
        .irq      (irq)
    );

    pit_readout u_readout (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_stb   (cfg_stb),
        .latch_stb (latch_stb),
        .rd_stb    (rd_en && !ctl_sel),
        .cnt       (cnt),
        .rd_byte   (rd_byte)
    );

    assign rdata = ctl_sel ? '0 : rd_byte;
endmodule

// File: tb/test_pit_channel.sv
`timescale 1ns/1ps
module test_pit_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       ctl_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tmr_out, irq;

    typedef struct {
        int    at;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t head;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   last_edge = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;

    pit_channel i_pit_channel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .ctl_sel (ctl_sel),
        .wdata   (wdata),
        .rdata   (rdata),
        .tmr_out (tmr_out),
        .irq     (irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor for interrupt pulses
    always @(negedge clk) begin
        if (mon_en) begin
            if (irq) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10 unexpected irq: actual cycle %0d expected none", cyc);
                end else begin
                    head = exp_q.pop_front();
                    if (head.at != cyc) begin
                        errors++;
                        $display("FAIL %s irq: actual cycle %0d expected %0d", head.tag, cyc, head.at);
                    end
                end
            end else if (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                checks++;
                errors++;
                head = exp_q.pop_front();
                $display("FAIL %s missed irq: actual none expected cycle %0d", head.tag, head.at);
            end
        end
    end

    task automatic wr(input bit ctl, input logic [7:0] v);
        ctl_sel = ctl;
        wdata   = v;
        wr_en   = 1'b1;
        @(negedge clk);
        last_edge = cyc;
        wr_en   = 1'b0;
        ctl_sel = 1'b0;
    endtask

    task automatic rd(output int v, output int at);
        ctl_sel = 1'b0;
        rd_en   = 1'b1;
        at      = cyc;
        #1 v    = int'(rdata);
        @(negedge clk);
        rd_en   = 1'b0;
    endtask

    task automatic push(input int at, input string tag);
        exp_t e;
        e.at  = at;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        #600000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p, lo, hi, at, l, expv, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        // R1 reset state
        #1;
        check("R1 tmr_out", tmr_out, 0);
        check("R1 irq", irq, 0);
        check("R1 rdata", rdata, 0);
        wr(1'b0, 8'h05);
        #1 check("R1 data write before config ignored", rdata, 0);

        // R5 periodic mode, N=10
        wr(1'b1, 8'h34);
        #1 check("R2 mode2 init high", tmr_out, 1);
        wr(1'b0, 8'd10);
        wr(1'b0, 8'd0);
        p = last_edge;
        push(p + 9, "R5");
        push(p + 19, "R5");
        push(p + 29, "R5");
        wait_until(p + 9);
        #1 check("R5 low cycle", tmr_out, 0);
        wait_until(p + 10);
        #1 check("R5 high after reload", tmr_out, 1);
        wait_until(p + 31);

        // R2 / R7 stop with mode 0 and count 0 (65536)
        wr(1'b1, 8'h30);
        #1 check("R2 mode0 init low", tmr_out, 0);
        wr(1'b0, 8'd0);
        wr(1'b0, 8'd0);
        p = last_edge;
        push(p + 65536, "R7");
        wait_until(p + 65535);
        #1 check("R7 still low", tmr_out, 0);
        wait_until(p + 65536);
        #1 check("R7 high at 65536", tmr_out, 1);

        // R4 / R8 / R9 mode 0, N=1000
        wr(1'b1, 8'h30);
        wr(1'b0, 8'hE8);
        wr(1'b0, 8'h03);
        p = last_edge;
        push(p + 1000, "R4");
        repeat (4) @(negedge clk);
        wr(1'b1, 8'h00);
        l = last_edge;
        expv = 1000 - (l - 1 - p);
        repeat (3) @(negedge clk);
        rd(lo, at);
        repeat (2) @(negedge clk);
        wr(1'b1, 8'h00);
        rd(hi, at);
        check("R8 latched value", lo + 256 * hi, expv);
        rd(lo, c);
        rd(hi, at);
        check("R9 live low byte", lo, (1000 - (c - p)) & 255);
        check("R9 live high byte", hi, ((1000 - (c + 1 - p)) >> 8) & 255);
        wr(1'b1, 8'h00);
        l = last_edge;
        expv = 1000 - (l - 1 - p);
        rd(lo, at);
        rd(hi, at);
        check("R8 second latch value", lo + 256 * hi, expv);
        ctl_sel = 1'b1;
        rd_en   = 1'b1;
        #1 check("R9 control port read", rdata, 0);
        @(negedge clk);
        rd_en   = 1'b0;
        ctl_sel = 1'b0;
        wait_until(p + 999);
        #1 check("R4 low before terminal", tmr_out, 0);
        wait_until(p + 1000);
        #1 check("R4 high at terminal", tmr_out, 1);
        wait_until(p + 1010);
        #1 check("R4 stays high", tmr_out, 1);

        // R6 strobe mode
        wr(1'b1, 8'h38);
        #1 check("R2 mode4 init high", tmr_out, 1);
        wr(1'b0, 8'd20);
        wr(1'b0, 8'd0);
        p = last_edge;
        push(p + 20, "R6");
        wait_until(p + 20);
        #1 check("R6 strobe low", tmr_out, 0);
        wait_until(p + 21);
        #1 check("R6 back high", tmr_out, 1);
        repeat (40) @(negedge clk);
        wr(1'b0, 8'd5);
        wr(1'b0, 8'd0);
        p = last_edge;
        push(p + 5, "R6");
        wait_until(p + 12);

        // R2 ignored control bytes
        wr(1'b1, 8'hB0);
        #1 check("R2 other channel ignored", tmr_out, 1);
        wr(1'b1, 8'h31);
        #1 check("R2 BCD ignored", tmr_out, 1);
        wr(1'b1, 8'h3C);
        #1 check("R2 bad mode ignored", tmr_out, 1);

        // R3 access variants and pointer reset
        wr(1'b1, 8'h18);
        wr(1'b0, 8'd7);
        p = last_edge;
        push(p + 7, "R3");
        wait_until(p + 9);
        wr(1'b1, 8'h28);
        wr(1'b0, 8'd1);
        p = last_edge;
        push(p + 256, "R3");
        wait_until(p + 258);
        wr(1'b1, 8'h38);
        wr(1'b0, 8'h55);
        wr(1'b1, 8'h38);
        wr(1'b0, 8'd12);
        wr(1'b0, 8'd0);
        p = last_edge;
        push(p + 12, "R3");
        wait_until(p + 20);

        check("R6 no pending events", exp_q.size(), 0);
        finish_run();
    end
endmodule